// File: doc/BRIEF.md
# Moore Machine State-Equivalence Engine

This block takes the transition table of a small Moore machine (one input bit, one output bit, up to eight states) and computes which states are equivalent. Software or a sequencer loads the table through a write port, one slot per write: the slot index, the successor taken when the input is 0, the successor taken when the input is 1, and the output bit of that state. A separate count input says how many of the slots, counted from slot 0, are in use.

A one-cycle start pulse latches the count and seeds a partition of the valid states by their output bit. From then on the engine runs one refinement pass per clock. Each pass gives every state a new class ID based on its own class and the classes of its two successors. The engine stops on the first pass that leaves the partition as it was. It then raises done and presents one class ID per slot. Each ID is the index of the lowest-numbered state equivalent to that slot. It also presents the class count, which is the state count of the minimal equivalent machine.

Top module: `fsm_minimiser`

## Requirements
- R1: A write stores the successor on input 0, the successor on input 1 and the output bit into the addressed slot. A write presented while the engine is busy is discarded.
- R2: A start pulse taken while the engine is not busy clears done and raises busy on the next cycle. It also latches the valid-state count. A start pulse presented while busy has no effect. Busy and done are never high together.
- R3: The first partition places two valid states in the same class exactly when their output bits are equal.
- R4: In every pass, two states stay together only if they share a class and, for each input value, their successors also share a class. Otherwise they are separated.
- R5: Passes continue until one leaves every class ID unchanged. Done rises on the cycle after that pass. A run never stays busy for more than NS cycles.
- R6: At done, the class ID of each valid slot equals the lowest index of a valid state equivalent to it. Class IDs are 3 bits per slot, and slot i occupies bits [3i+2:3i] of class_id.
- R7: At done, class_count equals the number of distinct equivalence classes among the valid states. This is the minimum state count.
- R8: Slots at or above the latched count report class ID 0 and do not affect any other slot's result. A count of 0 gives a class count of 0.
- R9: After done, class IDs, class count and done hold their values until the next accepted start, even if the table is rewritten.
- R10: After reset, busy and done are low, every class ID is 0 and class_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one table slot |
| wr_idx | input | IW | Slot being written |
| wr_next0 | input | IW | Successor state on input 0 |
| wr_next1 | input | IW | Successor state on input 1 |
| wr_out | input | 1 | Output bit of the state |
| cfg_count | input | IW+1 | Number of valid slots, sampled at start |
| start | input | 1 | One-cycle run request |
| busy | output | 1 | Refinement in progress |
| done | output | 1 | Results valid and held |
| class_id | output | NS*IW | Canonical class ID of each slot |
| class_count | output | IW+1 | Number of equivalence classes |

## Verification
The bench builds the engine with its default of eight slots and 3-bit state indices. At that size, a bench-side distinguishability fixed point can be computed for every machine the bench loads. That makes it practical to check every valid count from 0 to 8 over several hundred pseudo-random tables, as well as the two hand-worked tables. The small size also keeps the NS-pass latency bound and the masking of unused slots within reach on each run, together with the corner cases of one state and zero states.

// File: rtl/fsmmin_pkg.sv
// Package: shared definitions for the state-equivalence engine.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package fsmmin_pkg;
    // Controller phase of the engine.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } mm_phase_e;
endpackage

// File: rtl/fsmmin_table.sv
// Module: register file holding the Moore transition table, one slot per state.
// Assumes the caller gates writes (no write while a run is in progress).
module fsmmin_table #(
    parameter int NS = 8,
    parameter int IW = $clog2(NS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IW-1:0]    widx,
    input  logic [IW-1:0]    wn0,
    input  logic [IW-1:0]    wn1,
    input  logic             wout,
    output logic [NS*IW-1:0] nx0_flat,
    output logic [NS*IW-1:0] nx1_flat,
    output logic [NS-1:0]    outv
);
    for (genvar g = 0; g < NS; g++) begin : g_slot
        // Store one slot when it is addressed by an accepted write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nx0_flat[g*IW +: IW] <= '0;
                nx1_flat[g*IW +: IW] <= '0;
                outv[g]              <= 1'b0;
            end else if (we && widx == IW'(g)) begin
                nx0_flat[g*IW +: IW] <= wn0;
                nx1_flat[g*IW +: IW] <= wn1;
                outv[g]              <= wout;
            end
        end
    end
endmodule

// File: rtl/fsmmin_seed.sv
// Module: builds the first partition by grouping valid states on their output bit.
// Each valid state gets the index of the lowest valid state with the same output;
// invalid states get 0.
module fsmmin_seed #(
    parameter int NS = 8,
    parameter int IW = $clog2(NS)
) (
    input  logic [NS-1:0]    valid,
    input  logic [NS-1:0]    outv,
    output logic [NS*IW-1:0] seed_flat
);
    // Lowest-index search for a matching output bit.
    always_comb begin
        seed_flat = '0;
        for (int i = 0; i < NS; i++) begin
            logic [IW-1:0] pick;
            pick = '0;
            for (int j = NS - 1; j >= 0; j--) begin
                if (valid[j] && outv[j] == outv[i]) pick = IW'(j);
            end
            if (valid[i]) seed_flat[i*IW +: IW] = pick;
        end
    end
endmodule

// File: rtl/fsmmin_refine.sv
// Module: one refinement pass. A state's signature is its own class and the
// classes of its two successors. The new class is the lowest valid index with an
// equal signature. Assumes successors of valid states are valid.
module fsmmin_refine #(
    parameter int NS = 8,
    parameter int IW = $clog2(NS)
) (
    input  logic [NS-1:0]    valid,
    input  logic [NS*IW-1:0] cur_flat,
    input  logic [NS*IW-1:0] nx0_flat,
    input  logic [NS*IW-1:0] nx1_flat,
    output logic [NS*IW-1:0] nxt_flat,
    output logic             changed
);
    logic [IW-1:0] cls [NS];
    logic [IW-1:0] sc0 [NS];
    logic [IW-1:0] sc1 [NS];

    // Gather each state's signature from the current partition.
    always_comb begin
        for (int i = 0; i < NS; i++) begin
            cls[i] = cur_flat[i*IW +: IW];
        end
        for (int i = 0; i < NS; i++) begin
            sc0[i] = cls[nx0_flat[i*IW +: IW]];
            sc1[i] = cls[nx1_flat[i*IW +: IW]];
        end
    end

    // Assign the canonical new class and flag any difference from the old one.
    always_comb begin
        nxt_flat = '0;
        changed  = 1'b0;
        for (int i = 0; i < NS; i++) begin
            logic [IW-1:0] pick;
            pick = '0;
            for (int j = NS - 1; j >= 0; j--) begin
                if (valid[j] && cls[j] == cls[i] && sc0[j] == sc0[i] && sc1[j] == sc1[i])
                    pick = IW'(j);
            end
            if (valid[i]) nxt_flat[i*IW +: IW] = pick;
            if (nxt_flat[i*IW +: IW] != cls[i]) changed = 1'b1;
        end
    end
endmodule

// File: rtl/fsm_minimiser.sv
// Module: top of the state-equivalence engine. It holds the table, seeds the
// partition on start, runs one refinement pass per cycle until a pass changes
// nothing (bounded at NS passes), and then holds the results until the next start.
// Assumes the host loads the table before start and keeps successors inside the count.
module fsm_minimiser #(
    parameter int NS = 8,
    parameter int IW = $clog2(NS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [IW-1:0]    wr_next0,
    input  logic [IW-1:0]    wr_next1,
    input  logic             wr_out,
    input  logic [IW:0]      cfg_count,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [NS*IW-1:0] class_id,
    output logic [IW:0]      class_count
);
    import fsmmin_pkg::*;

    localparam logic [IW:0] PASS_LAST = (IW+1)'(NS - 1);

    mm_phase_e         phase;
    logic [IW:0]       cnt_q;
    logic [IW:0]       pass_q;
    logic [NS*IW-1:0]  cur_q;
    logic [NS*IW-1:0]  nx0_flat, nx1_flat, seed_flat, nxt_flat;
    logic [NS-1:0]     outv, valid_run, valid_cfg;
    logic              changed;
    logic              accept;

    assign busy   = (phase == PH_RUN);
    assign done   = (phase == PH_DONE);
    assign accept = start && !busy;

    // Valid-slot masks from the latched count and from the incoming count.
    always_comb begin
        for (int i = 0; i < NS; i++) begin
            valid_run[i] = (IW+1)'(i) < cnt_q;
            valid_cfg[i] = (IW+1)'(i) < cfg_count;
        end
    end

    fsmmin_table #(.NS(NS), .IW(IW)) u_table (
        .clk(clk), .rst_n(rst_n), .we(wr_en && !busy), .widx(wr_idx),
        .wn0(wr_next0), .wn1(wr_next1), .wout(wr_out),
        .nx0_flat(nx0_flat), .nx1_flat(nx1_flat), .outv(outv)
    );

    fsmmin_seed #(.NS(NS), .IW(IW)) u_seed (
        .valid(valid_cfg), .outv(outv), .seed_flat(seed_flat)
    );

    fsmmin_refine #(.NS(NS), .IW(IW)) u_refine (
        .valid(valid_run), .cur_flat(cur_q), .nx0_flat(nx0_flat),
        .nx1_flat(nx1_flat), .nxt_flat(nxt_flat), .changed(changed)
    );

    // Phase sequencing, partition register and pass counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt_q  <= '0;
            pass_q <= '0;
            cur_q  <= '0;
        end else if (phase == PH_RUN) begin
            cur_q  <= nxt_flat;
            pass_q <= pass_q + 1'b1;
            if (!changed || pass_q == PASS_LAST) phase <= PH_DONE;
        end else if (accept) begin
            cnt_q  <= cfg_count;
            cur_q  <= seed_flat;
            pass_q <= '0;
            phase  <= PH_RUN;
        end
    end

    assign class_id = cur_q;

    // Count the representatives: valid slots whose class is their own index.
    always_comb begin
        class_count = '0;
        for (int i = 0; i < NS; i++) begin
            if (valid_run[i] && cur_q[i*IW +: IW] == IW'(i)) class_count = class_count + 1'b1;
        end
    end
endmodule

// File: rtl/fsmmin_checker.sv
// Module: temporal checks on the state-equivalence engine, bound to its top.
// Assumes the synchronous active-low reset of the top.
module fsmmin_checker #(
    parameter int NS = 8,
    parameter int IW = $clog2(NS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [NS*IW-1:0] class_id,
    input logic [IW:0]      class_count,
    input logic [IW:0]      cnt_q
);
    logic [IW+1:0] run_len;

    // Count consecutive busy cycles already elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));
    p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < (IW+2)'(NS)));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(class_id) && $stable(class_count)));
    p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (class_count <= cnt_q && (cnt_q == '0 || class_count != '0)));

    for (genvar g = 0; g < NS; g++) begin : g_slot
        p_canon_r6: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (class_id[g*IW +: IW] <= IW'(g)));
        p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (done && cnt_q <= (IW+1)'(g)) |-> (class_id[g*IW +: IW] == '0));
    end
endmodule

bind fsm_minimiser fsmmin_checker #(.NS(NS), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .class_id(class_id), .class_count(class_count), .cnt_q(cnt_q)
);

// File: tb/fsm_minimiser_test.sv
`timescale 1ns/1ps
module fsm_minimiser_test;
    localparam int NS = 8;
    localparam int IW = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [IW-1:0]    wr_idx = '0, wr_next0 = '0, wr_next1 = '0;
    logic             wr_out = 1'b0;
    logic [IW:0]      cfg_count = '0;
    logic             start = 1'b0;
    logic             busy, done;
    logic [NS*IW-1:0] class_id;
    logic [IW:0]      class_count;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int m0 [NS], m1 [NS], mo [NS], exp_id [NS], exp_cnt, lat;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    fsm_minimiser #(.NS(NS), .IW(IW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_next0(wr_next0), .wr_next1(wr_next1), .wr_out(wr_out),
        .cfg_count(cfg_count), .start(start), .busy(busy), .done(done),
        .class_id(class_id), .class_count(class_count)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog R5: run did not finish, got %0d cycles expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic put(input int i, input int a, input int b, input int o);
        m0[i] = a; m1[i] = b; mo[i] = o;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(i); wr_next0 = IW'(a); wr_next1 = IW'(b); wr_out = o[0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Bench model: pairwise distinguishability fixed point over valid states.
    task automatic model(input int n);
        bit d [NS][NS];
        bit grow;
        for (int i = 0; i < NS; i++) for (int j = 0; j < NS; j++)
            d[i][j] = (i < n && j < n) ? (mo[i] != mo[j]) : 1'b1;
        grow = 1'b1;
        while (grow) begin
            grow = 1'b0;
            for (int i = 0; i < n; i++) for (int j = 0; j < n; j++)
                if (!d[i][j] && (d[m0[i]][m0[j]] || d[m1[i]][m1[j]])) begin
                    d[i][j] = 1'b1; grow = 1'b1;
                end
        end
        exp_cnt = 0;
        for (int i = 0; i < NS; i++) begin
            exp_id[i] = 0;
            if (i < n) begin
                for (int j = n - 1; j >= 0; j--) if (!d[i][j]) exp_id[i] = j;
                if (exp_id[i] == i) exp_cnt++;
            end
        end
    endtask

    // Pulse start, then count edges until done is seen at a falling edge.
    task automatic launch(input int n);
        @(negedge clk);
        cfg_count = (IW+1)'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < NS + 4) begin
            check("R2 done low while busy", int'(done), 0);
            @(negedge clk); lat++;
        end
    endtask

    task automatic verify(input string tag);
        check({tag, " R7 class count"}, int'(class_count), exp_cnt);
        for (int i = 0; i < NS; i++)
            check({tag, (i >= 0) ? " R6/R8 class id" : ""}, int'(class_id[i*IW +: IW]), exp_id[i]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 busy", int'(busy), 0);
        check("R10 done", int'(done), 0);
        check("R10 count", int'(class_count), 0);
        check("R10 ids", int'(class_id), 0);

        // Hand table 1: D and E merge, four classes (R3, R4)
        put(0,1,2,0); put(1,0,3,0); put(2,4,0,0); put(3,0,1,1); put(4,0,1,1);
        launch(5);
        check("R5 latency bound", (lat >= 1 && lat <= NS) ? 1 : 0, 1);
        exp_id = '{0,1,2,3,3,0,0,0}; exp_cnt = 4;
        verify("table1 R4");

        // R1 and R2: write and second start during a run are ignored
        @(negedge clk);
        cfg_count = 4'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b1; cfg_count = 4'd2;
        wr_en = 1'b1; wr_idx = 3'd3; wr_next0 = 3'd2; wr_next1 = 3'd2; wr_out = 1'b0;
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        while (!done) @(negedge clk);
        check("R2 count after ignored start", int'(class_count), 4);
        launch(5);
        check("R1 write during busy discarded", int'(class_count), 4);
        check("R1 slot 4 id", int'(class_id[4*IW +: IW]), 3);

        // R9 results hold while the table is rewritten
        put(3,3,3,0); put(4,4,4,0);
        repeat (3) @(negedge clk);
        check("R9 done held", int'(done), 1);
        check("R9 count held", int'(class_count), 4);
        check("R9 id held", int'(class_id[4*IW +: IW]), 3);

        // Hand table 2: A and F merge, five classes (R3, R4)
        put(0,1,2,0); put(1,0,3,1); put(2,1,0,1); put(3,3,0,0); put(4,3,1,0); put(5,1,2,0);
        launch(6);
        exp_id = '{0,1,2,3,4,0,0,0}; exp_cnt = 5;
        verify("table2 R3");

        // R8 edge: one state and zero states
        launch(1);
        check("R5 single state latency", lat, 1);
        check("R8 one state count", int'(class_count), 1);
        launch(0);
        check("R8 zero states count", int'(class_count), 0);
        check("R8 zero states ids", int'(class_id), 0);

        // Sweep: pseudo-random tables for every count 1..8
        for (int t = 0; t < 360; t++) begin
            int n;
            n = (t % NS) + 1;
            for (int i = 0; i < NS; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                // slots beyond n receive junk to exercise masking (R8)
                if (i < n) put(i, int'(lfsr[7:0]) % n, int'(lfsr[15:8]) % n, int'(lfsr[20] & lfsr[9]));
                else       put(i, int'(lfsr[2:0]), int'(lfsr[5:3]), int'(lfsr[6]));
            end
            model(n);
            launch(n);
            check("R5 sweep latency", (lat >= 1 && lat <= NS) ? 1 : 0, 1);
            verify("sweep R6 R8");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule